// File: doc/BRIEF.md
# Horner Odd-Polynomial Sine Evaluator

This block computes the sine of a first-quadrant angle. An unsigned fixed-point argument in [0, π/2] arrives with a one-cycle valid strobe. The block returns an unsigned fixed-point sine magnitude with its own one-cycle valid strobe, a fixed number of cycles later. The caller performs range reduction and restores the sign. Those steps stay outside this block.

The evaluation uses the odd polynomial sin(x) ≈ x·(1 + g·P(g)), where g = x² and P(g) is a degree-six polynomial in g with seven constant coefficients R1..R7. The coefficients are fitted over the interval to spread the error evenly, so the full expansion reaches order 15. One signed multiply-add unit, shared by every step, evaluates this expression. Each product is rounded to nearest at a 40-bit internal fraction. A small controller steps through four states: IDLE, SQUARE, HORNER and FINAL.

- In IDLE, an asserted strobe captures the argument (transition IDLE→SQUARE).
- In SQUARE, the unit forms g and loads R7 into the accumulator (SQUARE→HORNER).
- HORNER runs seven passes of acc = acc·g + c. The coefficient c takes the values R6, R5, …, R1 and then the unit constant. The state exits after the last pass (HORNER→FINAL).
- FINAL multiplies the accumulator by x and registers the result (FINAL→IDLE).

Top module: `sine_horner_eval`

## Requirements
- R1: When `in_valid` is high and the block is idle, the argument is captured at that clock edge and `busy` is high for the following 9 cycles.
- R2: `in_valid` pulses that arrive while `busy` is high are ignored: they neither change the argument being evaluated nor produce an extra result.
- R3: `out_valid` is a single-cycle pulse. It rises 9 clock edges after the capturing edge, in the cycle after `busy` falls.
- R4: The argument is unsigned with 30 fraction bits (Q2.30), and `out_sine` is unsigned with 31 fraction bits (Q1.31). For every argument in [0, 1686629713], `out_sine` is within ±2 LSB of sin(in_arg/2^30)·2^31.
- R5: `out_sine` never exceeds 2^31, which represents 1.0. A zero argument gives exactly 0, and the argument 1686629713 (π/2) gives a value within 2 LSB of 2^31.
- R6: One result takes one squaring pass, then seven Horner multiply-add passes (R6..R1 and then the constant 1), then one final multiply by x. All passes use a single shared multiply-add unit. The total is nine multiplies and seven additions.
- R7: `out_sine` holds its value in every cycle in which `out_valid` is low.
- R8: While `rst_n` is low, `busy`, `out_valid` and `out_sine` are all zero.
- R9: Each product is rounded to nearest at 40 fraction bits. For in-domain arguments, no intermediate value overflows the 44-bit signed internal word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Argument strobe |
| in_arg | input | ARG_W (32) | Angle, unsigned Q2.30, in [0, π/2] |
| busy | output | 1 | High while an evaluation is in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_sine | output | OUT_W (32) | Sine magnitude, unsigned Q1.31 |

## Verification
The embedded properties assume that every captured argument lies in the first quadrant, at or below 1686629713 in Q2.30. The no-overflow and upper-bound checks rely on that range. All bench stimulus is generated modulo that limit and includes both endpoints. A long stretch with `in_valid` held high and the argument changing every cycle exercises the ignore-while-busy rule. The cycle model accepts only the arguments that land on idle edges and predicts the result for each of them.

// File: rtl/sine_horner_pkg.sv
package sine_horner_pkg;

    // Number of Horner multiply-add passes after the squaring step
    localparam int TERMS = 7;
    localparam int IDX_W = $clog2(TERMS + 1);

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SQUARE,
        SH_HORNER,
        SH_FINAL
    } sh_state_e;

    // Index 0 is the unit term; indices 1..7 are the fitted odd-series terms
    function automatic real coef_real(input int k);
        case (k)
            0:       return 1.0;
            1:       return -0.16666666666666665052;
            2:       return 0.83333333333331650314e-2;
            3:       return -0.19841269841201840457e-3;
            4:       return 0.27557319210152756119e-5;
            5:       return -0.25052106798274584544e-7;
            6:       return 0.16058936490371589114e-9;
            default: return -0.76429178068910467734e-12;
        endcase
    endfunction

    function automatic longint to_fix(input real v, input int frac);
        return longint'(v * (2.0 ** real'(frac)));
    endfunction

endpackage

// File: rtl/sine_coef_rom.sv
module sine_coef_rom
    import sine_horner_pkg::*;
#(
    parameter int IW     = 44,
    parameter int FRAC_W = 40
) (
    input  logic [IDX_W-1:0]     idx,
    output logic signed [IW-1:0] coef
);

    logic signed [IW-1:0] tbl [TERMS+1];

    for (genvar k = 0; k <= TERMS; k++) begin : g_entry
        localparam logic signed [IW-1:0] VAL = IW'(to_fix(coef_real(k), FRAC_W));
        assign tbl[k] = VAL;
    end

    assign coef = tbl[idx];

endmodule

// File: rtl/sine_mac.sv
module sine_mac #(
    parameter int IW     = 44,
    parameter int FRAC_W = 40
) (
    input  logic signed [IW-1:0] a,
    input  logic signed [IW-1:0] b,
    input  logic signed [IW-1:0] c,
    output logic signed [IW-1:0] y,
    output logic                 ovf
);

    localparam int PW = 2 * IW;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC_W - 1);

    logic signed [PW-1:0] a_x, b_x, prod, rnd, shr, sum;
    logic [PW-IW:0]       top_bits;

    always_comb begin
        a_x      = PW'(a);
        b_x      = PW'(b);
        prod     = a_x * b_x;
        rnd      = prod + HALF;
        shr      = rnd >>> FRAC_W;
        sum      = shr + PW'(c);
        y        = sum[IW-1:0];
        top_bits = sum[PW-1:IW-1];
        ovf      = !((&top_bits) || !(|top_bits));
    end

endmodule

// File: rtl/sine_horner_ctrl.sv
module sine_horner_ctrl
    import sine_horner_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output sh_state_e        state,
    output logic [IDX_W-1:0] cnt,
    output logic             busy
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(TERMS - 1);

    sh_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SH_IDLE:   if (in_valid) state_d = SH_SQUARE;
            SH_SQUARE: begin
                state_d = SH_HORNER;
                cnt_d   = LAST;
            end
            SH_HORNER: begin
                if (cnt_q == '0) state_d = SH_FINAL;
                else             cnt_d   = cnt_q - IDX_W'(1);
            end
            SH_FINAL:  state_d = SH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state = state_q;
        cnt   = cnt_q;
        busy  = (state_q != SH_IDLE);
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_IDLE && in_valid) |=> (state_q == SH_SQUARE));

    p_square_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_SQUARE) |=> (state_q == SH_HORNER && cnt_q == LAST));

    p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HORNER && cnt_q != '0)
            |=> (state_q == SH_HORNER && cnt_q == $past(cnt_q) - IDX_W'(1)));

    p_horner_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HORNER && cnt_q == '0) |=> (state_q == SH_FINAL));

    p_final_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_FINAL) |=> (state_q == SH_IDLE));

endmodule

// File: rtl/sine_horner_eval.sv
module sine_horner_eval
    import sine_horner_pkg::*;
#(
    parameter int ARG_W    = 32,
    parameter int ARG_FRAC = 30,
    parameter int OUT_W    = 32,
    parameter int OUT_FRAC = 31,
    parameter int FRAC_W   = 40,
    parameter int IW       = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ARG_W-1:0] in_arg,
    output logic             busy,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sine
);

    localparam int ARG_SHIFT = FRAC_W - ARG_FRAC;
    localparam int DROP      = FRAC_W - OUT_FRAC;
    localparam logic signed [IW-1:0] HALF_O  = IW'(1) << (DROP - 1);
    localparam logic signed [IW-1:0] ONE_OUT = IW'(1) << OUT_FRAC;

    sh_state_e            state;
    logic [IDX_W-1:0]     cnt, rom_idx;
    logic signed [IW-1:0] x_r, g_r, acc_r;
    logic signed [IW-1:0] op_a, op_b, op_c, mac_y, coef, y_rnd;
    logic                 mac_ovf;
    logic [OUT_W-1:0]     out_r, out_next;
    logic                 out_valid_r;

    sine_horner_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .state    (state),
        .cnt      (cnt),
        .busy     (busy)
    );

    assign rom_idx = (state == SH_SQUARE) ? IDX_W'(TERMS) : cnt;

    sine_coef_rom #(.IW(IW), .FRAC_W(FRAC_W)) u_rom (
        .idx  (rom_idx),
        .coef (coef)
    );

    // shared multiply-add operand selection
    always_comb begin
        op_a = '0;
        op_b = '0;
        op_c = '0;
        unique case (state)
            SH_IDLE:   ;
            SH_SQUARE: begin op_a = x_r;   op_b = x_r; end
            SH_HORNER: begin op_a = acc_r; op_b = g_r; op_c = coef; end
            SH_FINAL:  begin op_a = acc_r; op_b = x_r; end
        endcase
    end

    sine_mac #(.IW(IW), .FRAC_W(FRAC_W)) u_mac (
        .a   (op_a),
        .b   (op_b),
        .c   (op_c),
        .y   (mac_y),
        .ovf (mac_ovf)
    );

    // round to output precision and clamp to [0, 1.0]
    always_comb begin
        y_rnd = (mac_y + HALF_O) >>> DROP;
        if (y_rnd < 0)             out_next = '0;
        else if (y_rnd > ONE_OUT)  out_next = OUT_W'(ONE_OUT);
        else                       out_next = OUT_W'(y_rnd);
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_r         <= '0;
            g_r         <= '0;
            acc_r       <= '0;
            out_r       <= '0;
            out_valid_r <= 1'b0;
        end else begin
            out_valid_r <= 1'b0;
            unique case (state)
                SH_IDLE:   if (in_valid) x_r <= IW'(in_arg) << ARG_SHIFT;
                SH_SQUARE: begin
                    g_r   <= mac_y;
                    acc_r <= coef;
                end
                SH_HORNER: acc_r <= mac_y;
                SH_FINAL:  begin
                    out_r       <= out_next;
                    out_valid_r <= 1'b1;
                end
            endcase
        end
    end

    assign out_valid = out_valid_r;
    assign out_sine  = out_r;

    p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> $stable(x_r));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_valid_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(state) == SH_FINAL));

    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sine <= OUT_W'(ONE_OUT)));

    p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && x_r == '0) |-> (out_sine == '0));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sine));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SH_IDLE) |-> !mac_ovf);

endmodule

// File: tb/sine_horner_eval_test.sv
module sine_horner_eval_test;

    localparam longint ARG_MAX = 64'd1686629713;  // round(pi/2 * 2^30)
    localparam real    ONE_Q   = 2147483648.0;    // 2^31
    localparam int     LAT     = 9;
    localparam int     GAP     = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_arg = '0;
    logic        busy, out_valid;
    logic [31:0] out_sine;

    int  cyc = 0;
    int  free_at = 0;
    int  t_q[$];
    real v_q[$];
    int  errors = 0;
    int  checks = 0;
    logic [31:0] last_out = '0;
    bit  done = 1'b0;

    sine_horner_eval uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_arg    (in_arg),
        .busy      (busy),
        .out_valid (out_valid),
        .out_sine  (out_sine)
    );

    always #10 clk = ~clk;

    function automatic real ref_sine(input logic [31:0] a);
        real e;
        e = $sin(real'(a) / 1073741824.0) * ONE_Q;
        if (e > ONE_Q) e = ONE_Q;
        return e;
    endfunction

    // behavioural cycle model: accept on idle edges only (R1, R2)
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            free_at = 0;
        end else if (in_valid && cyc >= free_at) begin
            t_q.push_back(cyc + LAT);
            v_q.push_back(ref_sine(in_arg));
            free_at = cyc + GAP;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit  exp_v;
            bit  exp_b;
            exp_v = (t_q.size() > 0) && (t_q[0] == cyc);
            exp_b = (cyc < free_at - 1);
            checks++;
            if (busy !== exp_b) begin
                errors++;
                $display("FAIL R1 busy cycle %0d: got %0b expected %0b", cyc, busy, exp_b);
            end
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL R3 R6 out_valid cycle %0d: got %0b expected %0b", cyc, out_valid, exp_v);
            end
            if (exp_v) begin
                real e, d;
                void'(t_q.pop_front());
                e = v_q.pop_front();
                d = real'(out_sine) - e;
                checks++;
                if (d > 2.0 || d < -2.0) begin
                    errors++;
                    $display("FAIL R4 R9 value: got %0d expected %f", out_sine, e);
                end
                checks++;
                if (out_sine > 32'h8000_0000) begin
                    errors++;
                    $display("FAIL R5 bound: got %0d expected <= %0d", out_sine, 32'h8000_0000);
                end
                last_out = out_sine;
            end else begin
                checks++;
                if (out_sine !== last_out) begin
                    errors++;
                    $display("FAIL R7 hold: got %0d expected %0d", out_sine, last_out);
                end
            end
        end
    end

    task automatic send(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        in_arg   = a;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic check_exact(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_exact({31'd0, busy}, 32'd0, "R8 busy");
        check_exact({31'd0, out_valid}, 32'd0, "R8 out_valid");
        check_exact(out_sine, 32'd0, "R8 out_sine");
        rst_n = 1'b1;
        @(negedge clk);

        // R5: zero argument gives exactly zero
        send(32'd0);
        check_exact(out_sine, 32'd0, "R5 zero input");

        // R5: quarter-turn argument close to one, not above
        send(ARG_MAX[31:0]);
        checks++;
        if (out_sine > 32'h8000_0000 || out_sine < 32'h7FFF_FFFE) begin
            errors++;
            $display("FAIL R5 pi/2: got %0d expected %0d", out_sine, 32'h8000_0000);
        end

        // R4: smallest nonzero argument, pi/6, pi/4
        send(32'd1);
        send(32'd562209904);
        send(32'd843314857);

        // R4: spread across the domain
        for (int i = 0; i < 150; i++) begin
            longint v;
            v = (longint'(i) * 64'd987654321 + 64'd12345) % (ARG_MAX + 64'd1);
            send(v[31:0]);
        end

        // R2: strobe held high, argument changing every cycle
        @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            longint v;
            v = (longint'(i) * 64'd28111 * 64'd1000 + 64'd7) % (ARG_MAX + 64'd1);
            in_valid = 1'b1;
            in_arg   = v[31:0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (GAP + 2) @(negedge clk);

        checks++;
        if (t_q.size() != 0) begin
            errors++;
            $display("FAIL R3 pending results: got %0d expected 0", t_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule